// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog with Vector-Address Service

This block watches that software keeps running. A free-running counter advances on every clock while the watchdog is enabled. If software does not service it before the selected period ends, the block raises a reset request for one clock. The request is the block's only action: it never produces an interrupt.

Software services the watchdog by writing any value to the service address. That address is the low byte of the reset vector, so a read of the same address returns the vector byte supplied on `vec_lo` and leaves the counter alone. A rate bit from the configuration register selects the period:

- 2^LONG_EXP − 2^SUB_EXP clocks when the bit is 0. This is the default after reset, because a reset clears the configuration bit.
- 2^SHORT_EXP − 2^SUB_EXP clocks when the bit is 1.

A disable bit from the configuration register turns the watchdog off. Monitor mode suppresses it in two ways:

- Entry with the test voltage present on the interrupt pin turns the watchdog off until the next power-on reset.
- Entry because the reset vectors are blank turns it off only while the test voltage is present.

Top module: `cop_watchdog`

## Requirements
- R1: While `por` is high and in the cycle after it falls, `rst_req` and `rd_data` are 0. The counter and the monitor state clear. The first pulse after `por` falls comes on the P-th counting edge, where P is the selected period.
- R2: With `cfg_short_rate`=0 and the watchdog enabled, `rst_req` rises exactly P_L = 2^LONG_EXP − 2^SUB_EXP clock edges after the edge that cleared the counter.
- R3: With `cfg_short_rate`=1, that distance is P_S = 2^SHORT_EXP − 2^SUB_EXP edges.
- R4: A write (`bus_wr`=1) with `bus_addr` equal to SVC_ADDR (default 16'hFFFF) clears the counter and starts a new full period. A write to any other address has no effect.
- R5: A read (`bus_rd`=1) of SVC_ADDR puts `vec_lo` on `rd_data` in the next cycle. Otherwise `rd_data` is 0. A read never changes the count.
- R6: While `cfg_off`=1, `rst_req` stays 0 and the count holds at zero. After `cfg_off` is cleared, a full period is needed before a pulse.
- R7: `rst_req` is high for exactly one clock. The counter restarts from zero on the pulse edge, so the next pulse follows after another full period.
- R8: A service write that is captured on the edge where the terminal count would fire suppresses that pulse and starts a new period.
- R9: Changing `cfg_short_rate` does not clear the count. If the count is already at or past the new terminal value, `rst_req` fires on the next edge.
- R10: If `mon_enter` is high while `tst_hv`=1, the watchdog stays off until `por`, whatever `tst_hv` does afterwards.
- R11: If `mon_enter` is high with `mon_blank`=1 and `tst_hv`=0, the watchdog is off only in cycles where `tst_hv`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal free-running clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| cfg_short_rate | input | 1 | Rate select: 1 = short period, 0 = long period |
| cfg_off | input | 1 | Disable: 1 = watchdog off |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| vec_lo | input | 8 | Low byte of the reset vector |
| mon_enter | input | 1 | One-cycle pulse when monitor mode is entered |
| mon_blank | input | 1 | Monitor entry was caused by blank reset vectors |
| tst_hv | input | 1 | Test voltage present on the interrupt pin |
| rst_req | output | 1 | One-clock reset request |
| rd_data | output | 8 | Read data, valid the cycle after a read |

## Verification
A wrong count or terminal value appears at `rst_req` as a pulse that comes early or late by a measurable number of edges. The pulse may also vanish, or last more than one clock. A wrong monitor or enable state shows as a pulse during a window where none may occur, or as a missing pulse one period after enabling. A faulty address decode shows up within one period, either as a missed clear or as a stray `rd_data` byte on the very next cycle. A cycle-level model in the bench compares both outputs on every clock, so most faults are reported within one period of the fault.

// File: rtl/cop_pkg.sv
package cop_pkg;

    typedef enum logic [1:0] {
        MON_NONE  = 2'd0,
        MON_BLANK = 2'd1,
        MON_LOCK  = 2'd2
    } mon_state_e;

    typedef struct packed {
        logic svc;
        logic rd;
    } bus_evt_t;

    typedef struct packed {
        logic short_rate;
        logic off;
    } cfg_t;

    // Compare limit for a period of 2^e_main - 2^e_sub counting edges.
    function automatic int unsigned term_count(input int unsigned e_main,
                                               input int unsigned e_sub);
        return (32'd1 << e_main) - (32'd1 << e_sub) - 32'd1;
    endfunction

endpackage

// File: rtl/cop_bus_decode.sv
module cop_bus_decode
    import cop_pkg::*;
#(
    parameter int unsigned           ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]     SVC_ADDR = '1
) (
    input  logic              clk,
    input  logic              por,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [7:0]        vec_lo,
    output bus_evt_t          evt,
    output logic [7:0]        rd_data
);
    logic hit;

    assign hit     = (addr == SVC_ADDR);
    assign evt.svc = wr & hit;
    assign evt.rd  = rd & hit;

    always_ff @(posedge clk) begin
        if (por) begin
            rd_data <= '0;
        end else if (evt.rd) begin
            rd_data <= vec_lo;
        end else begin
            rd_data <= '0;
        end
    end
endmodule

// File: rtl/cop_mon_guard.sv
module cop_mon_guard
    import cop_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  cfg_t       cfg,
    input  logic       mon_enter,
    input  logic       mon_blank,
    input  logic       tst_hv,
    output mon_state_e state,
    output logic       run
);
    mon_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            MON_NONE: begin
                if (mon_enter && tst_hv)         nxt = MON_LOCK;
                else if (mon_enter && mon_blank) nxt = MON_BLANK;
            end
            MON_BLANK: begin
                if (mon_enter && tst_hv)         nxt = MON_LOCK;
            end
            default:                             nxt = MON_LOCK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por) state <= MON_NONE;
        else     state <= nxt;
    end

    assign run = !cfg.off && (state != MON_LOCK) &&
                 !((state == MON_BLANK) && tst_hv);
endmodule

// File: rtl/cop_counter.sv
module cop_counter #(
    parameter int unsigned CNT_W  = 18,
    parameter int unsigned TERM_L = 262127,
    parameter int unsigned TERM_S = 8175
) (
    input  logic             clk,
    input  logic             por,
    input  logic             run,
    input  logic             svc,
    input  logic             short_rate,
    output logic [CNT_W-1:0] cnt,
    output logic             rst_req
);
    localparam logic [CNT_W-1:0] LIM_L = CNT_W'(TERM_L);
    localparam logic [CNT_W-1:0] LIM_S = CNT_W'(TERM_S);

    logic [CNT_W-1:0] lim;
    logic             at_term;

    assign lim     = short_rate ? LIM_S : LIM_L;
    assign at_term = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (por) begin
            cnt     <= '0;
            rst_req <= 1'b0;
        end else if (!run || svc) begin
            cnt     <= '0;
            rst_req <= 1'b0;
        end else if (at_term) begin
            cnt     <= '0;
            rst_req <= 1'b1;
        end else begin
            cnt     <= cnt + 1'b1;
            rst_req <= 1'b0;
        end
    end
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
    import cop_pkg::*;
#(
    parameter int unsigned       LONG_EXP  = 18,
    parameter int unsigned       SHORT_EXP = 13,
    parameter int unsigned       SUB_EXP   = 4,
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] SVC_ADDR  = '1
) (
    input  logic              clk,
    input  logic              por,
    input  logic              cfg_short_rate,
    input  logic              cfg_off,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        vec_lo,
    input  logic              mon_enter,
    input  logic              mon_blank,
    input  logic              tst_hv,
    output logic              rst_req,
    output logic [7:0]        rd_data
);
    localparam int unsigned CNT_W  = LONG_EXP;
    localparam int unsigned TERM_L = term_count(LONG_EXP, SUB_EXP);
    localparam int unsigned TERM_S = term_count(SHORT_EXP, SUB_EXP);

    cfg_t             cfg;
    bus_evt_t         bus_evt;
    mon_state_e       mon_st;
    logic             run;
    logic [CNT_W-1:0] cnt_q;

    assign cfg.short_rate = cfg_short_rate;
    assign cfg.off        = cfg_off;

    cop_bus_decode #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_bus (
        .clk     (clk),
        .por     (por),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .vec_lo  (vec_lo),
        .evt     (bus_evt),
        .rd_data (rd_data)
    );

    cop_mon_guard u_guard (
        .clk       (clk),
        .por       (por),
        .cfg       (cfg),
        .mon_enter (mon_enter),
        .mon_blank (mon_blank),
        .tst_hv    (tst_hv),
        .state     (mon_st),
        .run       (run)
    );

    cop_counter #(.CNT_W(CNT_W), .TERM_L(TERM_L), .TERM_S(TERM_S)) u_cnt (
        .clk        (clk),
        .por        (por),
        .run        (run),
        .svc        (bus_evt.svc),
        .short_rate (cfg.short_rate),
        .cnt        (cnt_q),
        .rst_req    (rst_req)
    );
endmodule

// File: rtl/cop_watchdog_chk.sv
module cop_watchdog_chk
    import cop_pkg::*;
#(
    parameter int unsigned CNT_W  = 18,
    parameter int unsigned TERM_L = 262127,
    parameter int unsigned TERM_S = 8175
) (
    input logic             clk,
    input logic             por,
    input logic             rst_req,
    input logic [CNT_W-1:0] cnt,
    input logic             run,
    input logic             svc,
    input logic             rd,
    input mon_state_e       mon_st
);
    // R7: one-clock pulse that leaves the counter at zero
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (por)
        rst_req |=> !rst_req);
    assert_restart_R7: assert property (@(posedge clk) disable iff (por)
        rst_req |-> (cnt == '0));

    // R4, R8: a service write clears and suppresses
    assert_service_clears_R4: assert property (@(posedge clk) disable iff (por)
        (run && svc) |=> ((cnt == '0) && !rst_req));

    // R6: disabled means held at zero and silent
    assert_off_holds_R6: assert property (@(posedge clk) disable iff (por)
        !run |=> ((cnt == '0) && !rst_req));

    // R5: a read leaves counting untouched
    assert_read_neutral_R5: assert property (@(posedge clk) disable iff (por)
        (run && rd && !svc && (cnt < CNT_W'(TERM_S)))
            |=> (cnt == $past(cnt) + 1'b1));

    // R10: lock persists until power-on reset
    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (por)
        (mon_st == MON_LOCK) |=> (mon_st == MON_LOCK));

    // R2: the count never passes the long limit
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (por)
        cnt <= CNT_W'(TERM_L));
endmodule

bind cop_watchdog cop_watchdog_chk #(
    .CNT_W(CNT_W), .TERM_L(TERM_L), .TERM_S(TERM_S)
) u_chk (
    .clk     (clk),
    .por     (por),
    .rst_req (rst_req),
    .cnt     (cnt_q),
    .run     (run),
    .svc     (bus_evt.svc),
    .rd      (bus_evt.rd),
    .mon_st  (mon_st)
);

// File: tb/test_cop_watchdog.sv
module test_cop_watchdog;
    localparam int LE = 9;
    localparam int SE = 6;
    localparam int BE = 2;
    localparam int PL = (1 << LE) - (1 << BE);   // 508
    localparam int PS = (1 << SE) - (1 << BE);   // 60

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        cfg_short_rate = 1'b0;
    logic        cfg_off = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  vec_lo = 8'h5A;
    logic        mon_enter = 1'b0;
    logic        mon_blank = 1'b0;
    logic        tst_hv = 1'b0;
    logic        rst_req;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;

    cop_watchdog #(.LONG_EXP(LE), .SHORT_EXP(SE), .SUB_EXP(BE)) i_cop_watchdog (
        .clk(clk), .por(por), .cfg_short_rate(cfg_short_rate), .cfg_off(cfg_off),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .vec_lo(vec_lo),
        .mon_enter(mon_enter), .mon_blank(mon_blank), .tst_hv(tst_hv),
        .rst_req(rst_req), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    // Reference model built from the requirements
    int       m_cnt = 0;
    int       m_mon = 0;          // 0 none, 1 blank entry, 2 locked
    logic     m_rst = 1'b0;
    logic [7:0] m_rd = 8'h00;

    always @(posedge clk) begin
        if (por) begin
            m_cnt = 0; m_mon = 0; m_rst = 1'b0; m_rd = 8'h00;
        end else begin
            automatic bit run = !cfg_off && (m_mon != 2) && !((m_mon == 1) && tst_hv);
            automatic bit svc = bus_wr && (bus_addr == 16'hFFFF);
            automatic int lim = cfg_short_rate ? PS - 1 : PL - 1;
            m_rd = (bus_rd && bus_addr == 16'hFFFF) ? vec_lo : 8'h00;
            if (!run || svc) begin m_cnt = 0; m_rst = 1'b0; end
            else if (m_cnt >= lim) begin m_cnt = 0; m_rst = 1'b1; end
            else begin m_cnt = m_cnt + 1; m_rst = 1'b0; end
            if (mon_enter && tst_hv) m_mon = 2;
            else if (mon_enter && mon_blank && m_mon == 0) m_mon = 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check("R2 model rst_req", int'(rst_req), int'(m_rst));
        check("R5 model rd_data", int'(rd_data), int'(m_rd));
        bus_wr = 1'b0; bus_rd = 1'b0; mon_enter = 1'b0;
    endtask

    task automatic service();
        bus_addr = 16'hFFFF; bus_wr = 1'b1;
        tick();
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin tick(); n++; end while (!rst_req && n < 2000);
    endtask

    task automatic idle(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin tick(); if (rst_req) pulses++; end
    endtask

    task automatic do_por();
        por = 1'b1; tick(); tick(); por = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int p;
        void'($urandom(32'd1234));
        tick();
        check("R1 rst_req in reset", int'(rst_req), 0);
        check("R1 rd_data in reset", int'(rd_data), 0);
        por = 1'b0;
        wait_pulse(n);
        check("R1 first pulse after por", n, PL);

        // R2 and R7: long period, one-clock pulse, restart
        service();
        wait_pulse(n);
        check("R2 long period", n, PL);
        tick();
        check("R7 pulse width", int'(rst_req), 0);
        wait_pulse(n);
        check("R7 restart period", n, PL - 1);

        // R3: short period
        cfg_short_rate = 1'b1;
        service();
        wait_pulse(n);
        check("R3 short period", n, PS);

        // R4: write elsewhere ignored, write to the vector address clears
        service();
        idle(40, p);
        bus_addr = 16'hFFFE; bus_wr = 1'b1; tick();
        wait_pulse(n);
        check("R4 other address ignored", n, PS - 41);
        service();
        idle(40, p);
        service();
        wait_pulse(n);
        check("R4 service restarts", n, PS);

        // R5: read returns the vector byte and leaves the count
        service();
        vec_lo = 8'hC3; bus_addr = 16'hFFFF; bus_rd = 1'b1; tick();
        check("R5 read data", int'(rd_data), 8'hC3);
        tick();
        check("R5 read data clears", int'(rd_data), 0);
        wait_pulse(n);
        check("R5 read keeps count", n, PS - 2);

        // R8: service on the terminal edge suppresses
        service();
        idle(PS - 1, p);
        service();
        check("R8 pulse suppressed", int'(rst_req), 0);
        wait_pulse(n);
        check("R8 new period", n, PS);

        // R9: rate change keeps the count
        cfg_short_rate = 1'b0;
        service();
        idle(100, p);
        cfg_short_rate = 1'b1;
        tick();
        check("R9 past new limit fires", int'(rst_req), 1);
        cfg_short_rate = 1'b0;
        service();
        idle(30, p);
        cfg_short_rate = 1'b1;
        wait_pulse(n);
        check("R9 count not cleared", n, PS - 30);

        // R6: disable
        cfg_off = 1'b1;
        idle(PL + 50, p);
        check("R6 no pulse while off", p, 0);
        cfg_off = 1'b0;
        wait_pulse(n);
        check("R6 full period after enable", n, PS);

        // R10: entry with test voltage locks off until por
        tst_hv = 1'b1; mon_enter = 1'b1; tick();
        tst_hv = 1'b0;
        idle(PL + 100, p);
        check("R10 locked off", p, 0);
        do_por();
        wait_pulse(n);
        check("R10 por releases", n, PS);

        // R11: blank-vector entry, off only while voltage present
        do_por();
        mon_blank = 1'b1; mon_enter = 1'b1; tick();
        mon_blank = 1'b0;
        tst_hv = 1'b1;
        idle(PS * 3, p);
        check("R11 off while voltage", p, 0);
        tst_hv = 1'b0;
        wait_pulse(n);
        check("R11 runs without voltage", n, PS);

        // Random phase against the model
        do_por();
        for (int i = 0; i < 20000; i++) begin
            automatic int r = int'($urandom_range(0, 999));
            vec_lo = 8'($urandom);
            bus_addr = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
            bus_wr = (r < 4);
            bus_rd = (r >= 10 && r < 200);
            if (r >= 995) cfg_short_rate = ~cfg_short_rate;
            if (r >= 990 && r < 993) cfg_off = ~cfg_off;
            tst_hv = ($urandom_range(0, 49) == 0) ? ~tst_hv : tst_hv;
            mon_blank = $urandom_range(0, 1) == 1;
            mon_enter = ($urandom_range(0, 3999) == 0);
            if ($urandom_range(0, 2999) == 0) do_por();
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule